// File: doc/BRIEF.md
# Store Queue Request Scheduler

This block sits in front of an L1 data cache. It takes one memory request per cycle from the core, sorts it by kind, and decides when that request may start. Stores never go straight to the cache. They enter a small first-in first-out store queue, and the queue later drains them into the cache one at a time. Loads can run past buffered stores. If a load matches a buffered store, it takes the data of the youngest matching store and does not touch the cache. Reserved loads, conditional stores and fences wait until every buffered store has been written and the cache is idle.

The cache hit/miss machinery is outside the block. The cache accepts one operation at a time from the issue port and pulses a completion input when that operation finishes. The block supports only one operation in the cache at a time. It releases a queue entry only after the cache reports that the store held in that entry has completed. The drain of buffered stores gives way to a waiting load and to nothing else.

Top module: `stq_sched`

## Requirements
- R1: After reset the issue, forward and dequeue outputs are low and the store queue is empty, so a fence is accepted at once.
- R2: A store request from the core is never issued to the cache directly. Every issued store carries the drain flag (`iss_drain`=1), and no issue follows the acceptance of a store.
- R3: A load whose address matches no buffered store is accepted whenever the cache is idle, even if the queue holds entries. It is issued (kind code 0) in the cycle after acceptance, with its own address.
- R4: A reserved load (kind code 2) or conditional store (kind code 3) is accepted only when the queue is empty and the cache is idle. It is issued with its address and write data in the next cycle.
- R5: A fence (kind code 4) is accepted only when the queue is empty and the cache is idle, and it issues nothing to the cache.
- R6: When the cache is idle, the queue is not empty and no load is waiting, the oldest buffered store is issued (kind code 1, drain flag set) in the next cycle. Stores leave in arrival order.
- R7: While a load request is present at the core port, no buffered store is issued in the following cycle.
- R8: A load whose address matches one or more buffered stores is accepted even while the cache is busy. In the next cycle it returns the data of the youngest matching store on the forward port, and nothing is issued for it.
- R9: When the queue holds DEPTH entries, a store request is not accepted (`req_ready` low).
- R10: At most one operation is in the cache. After an issue, nothing else is issued until the cycle after `cache_done`.
- R11: `sq_deq` pulses for one cycle in the cycle after `cache_done` completes a drained store. A completion that belongs to a load or an atomic releases no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_kind | input | 3 | 0 load, 1 store, 2 reserved load, 3 conditional store, 4 fence |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted this cycle |
| iss_valid | output | 1 | Operation sent to the cache (one-cycle pulse) |
| iss_kind | output | 3 | Kind code of the issued operation |
| iss_addr | output | AW | Address of the issued operation |
| iss_data | output | DW | Write data of the issued operation |
| iss_drain | output | 1 | Issued operation is a store drained from the queue |
| cache_done | input | 1 | Cache finished the operation in flight |
| fwd_valid | output | 1 | Forwarded load data valid |
| fwd_data | output | DW | Data of the youngest matching buffered store |
| sq_deq | output | 1 | Oldest queue entry released |

## Verification
The assertions take it as given that the cache raises `cache_done` only while an operation it received is still outstanding, and only once for each issue, no earlier than the cycle in which `iss_valid` is seen. They also take it as given that `req_kind` stays within the five defined codes. The bench acts as the cache: it records each issue and answers with one completion after a random delay of zero to several cycles. It draws request kinds only from the defined codes, and addresses from a pool of four lines so that forwarding and youngest-match cases come up often. The bench runs phases with long cache latency and many stores to fill the queue, and phases with short latency to cover frequent drains.

// File: rtl/stq_pkg.sv
package stq_pkg;
  typedef enum logic [2:0] {
    K_LOAD   = 3'd0,
    K_STORE  = 3'd1,
    K_LDRES  = 3'd2,
    K_STCOND = 3'd3,
    K_FENCE  = 3'd4
  } req_kind_e;
endpackage

// File: rtl/stq_fifo.sv
module stq_fifo #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        enq,
  input  logic [AW-1:0]               enq_addr,
  input  logic [DW-1:0]               enq_data,
  input  logic                        deq,
  input  logic [AW-1:0]               probe_addr,
  output logic [AW-1:0]               head_addr,
  output logic [DW-1:0]               head_data,
  output logic                        full,
  output logic                        empty,
  output logic                        hit,
  output logic [DW-1:0]               hit_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (enq) begin
      addr_mem[tail] <= enq_addr;
      data_mem[tail] <= enq_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (enq) tail <= bump(tail);
      if (deq) head <= bump(head);
      unique case ({enq, deq})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = addr_mem[head];
  assign head_data = data_mem[head];

  // Walk from oldest to youngest; the last match wins, giving the youngest store.
  always_comb begin
    int j;
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      j = int'(head) + i;
      if (j >= DEPTH) j = j - DEPTH;
      if (CW'(i) < count && addr_mem[PW'(j)] == probe_addr) begin
        hit      = 1'b1;
        hit_data = data_mem[PW'(j)];
      end
    end
  end

  // R9: a full queue never takes another entry
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst) full |-> !enq);
  // R11: an entry is released only when one exists
  p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst) deq |-> !empty);
endmodule

// File: rtl/stq_ctrl.sv
module stq_ctrl
  import stq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  req_kind_e     req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          cache_done,
  input  logic          fwd_hit,
  input  logic [DW-1:0] fwd_hit_data,
  input  logic          sq_empty,
  input  logic          sq_full,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          enq,
  output logic          deq,
  output logic          iss_valid,
  output req_kind_e     iss_kind,
  output logic [AW-1:0] iss_addr,
  output logic [DW-1:0] iss_data,
  output logic          iss_drain,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data,
  output logic          sq_deq
);
  logic busy, busy_drain;
  logic ld_wait, accept, core_iss, drain_go;

  always_comb begin
    unique case (req_kind)
      K_LOAD:                    req_ready = fwd_hit || !busy;
      K_STORE:                   req_ready = !sq_full;
      K_LDRES, K_STCOND, K_FENCE: req_ready = sq_empty && !busy;
      default:                   req_ready = 1'b0;
    endcase
  end

  assign ld_wait  = req_valid && (req_kind == K_LOAD);
  assign accept   = req_valid && req_ready;
  assign core_iss = accept && ((req_kind == K_LOAD && !fwd_hit) ||
                               req_kind == K_LDRES || req_kind == K_STCOND);
  assign drain_go = !sq_empty && !busy && !ld_wait;
  assign enq      = accept && (req_kind == K_STORE);
  assign deq      = cache_done && busy && busy_drain;

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid  <= 1'b0;
      iss_kind   <= K_LOAD;
      iss_addr   <= '0;
      iss_data   <= '0;
      iss_drain  <= 1'b0;
      fwd_valid  <= 1'b0;
      fwd_data   <= '0;
      sq_deq     <= 1'b0;
      busy       <= 1'b0;
      busy_drain <= 1'b0;
    end else begin
      iss_valid <= core_iss || drain_go;
      if (core_iss) begin
        iss_kind  <= req_kind;
        iss_addr  <= req_addr;
        iss_data  <= req_wdata;
        iss_drain <= 1'b0;
      end else if (drain_go) begin
        iss_kind  <= K_STORE;
        iss_addr  <= head_addr;
        iss_data  <= head_data;
        iss_drain <= 1'b1;
      end
      fwd_valid <= accept && (req_kind == K_LOAD) && fwd_hit;
      fwd_data  <= fwd_hit_data;
      sq_deq    <= deq;
      if (core_iss || drain_go) begin
        busy       <= 1'b1;
        busy_drain <= drain_go;
      end else if (cache_done) begin
        busy <= 1'b0;
      end
    end
  end

  // R10: nothing new reaches the cache while an operation is still outstanding
  p_single_flight_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !cache_done) |=> !iss_valid);
  // R4: atomics start only from an empty queue
  p_atomic_drained_r4: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && (iss_kind == K_LDRES || iss_kind == K_STCOND)) |-> $past(sq_empty));
  // R2: stores reach the cache only through the queue
  p_store_via_queue_r2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_kind == K_STORE) |-> iss_drain);
  // R7: a waiting load holds off the drain
  p_drain_yields_r7: assert property (@(posedge clk) disable iff (rst)
    ld_wait |=> !(iss_valid && iss_drain));
  // R5: a fence sends nothing to the cache
  p_fence_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && req_kind == K_FENCE) |=> !iss_valid);
  // R11: release follows a completion
  p_deq_after_done_r11: assert property (@(posedge clk) disable iff (rst)
    sq_deq |-> $past(cache_done));
endmodule

// File: rtl/stq_sched.sv
module stq_sched
  import stq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          iss_valid,
  output logic [2:0]    iss_kind,
  output logic [AW-1:0] iss_addr,
  output logic [DW-1:0] iss_data,
  output logic          iss_drain,
  input  logic          cache_done,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data,
  output logic          sq_deq
);
  logic          enq, deq, sq_full, sq_empty, fwd_hit;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, fwd_hit_data;
  req_kind_e     iss_kind_e;

  stq_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .enq        (enq),
    .enq_addr   (req_addr),
    .enq_data   (req_wdata),
    .deq        (deq),
    .probe_addr (req_addr),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .full       (sq_full),
    .empty      (sq_empty),
    .hit        (fwd_hit),
    .hit_data   (fwd_hit_data)
  );

  stq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_kind     (req_kind_e'(req_kind)),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_ready    (req_ready),
    .cache_done   (cache_done),
    .fwd_hit      (fwd_hit),
    .fwd_hit_data (fwd_hit_data),
    .sq_empty     (sq_empty),
    .sq_full      (sq_full),
    .head_addr    (head_addr),
    .head_data    (head_data),
    .enq          (enq),
    .deq          (deq),
    .iss_valid    (iss_valid),
    .iss_kind     (iss_kind_e),
    .iss_addr     (iss_addr),
    .iss_data     (iss_data),
    .iss_drain    (iss_drain),
    .fwd_valid    (fwd_valid),
    .fwd_data     (fwd_data),
    .sq_deq       (sq_deq)
  );

  assign iss_kind = iss_kind_e;
endmodule

// File: tb/stq_sched_tb_top.sv
`timescale 1ns/1ps
module stq_sched_tb_top;
  localparam int AW = 16, DW = 32, DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, cache_done = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, iss_valid, iss_drain, fwd_valid, sq_deq;
  logic [2:0] iss_kind;
  logic [AW-1:0] iss_addr;
  logic [DW-1:0] iss_data, fwd_data;

  always #10 clk = ~clk;

  stq_sched #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_addr(iss_addr),
    .iss_data(iss_data), .iss_drain(iss_drain), .cache_done(cache_done),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .sq_deq(sq_deq)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  // bench model of the queue and of the cache
  logic [AW-1:0] ma[$];
  logic [DW-1:0] md[$];
  bit   busy = 0, busy_drain = 0;
  int   lat = 0;
  bit   e_iss_v = 0, e_fwd_v = 0, e_deq = 0;
  logic [63:0] e_iss = '0;
  logic [DW-1:0] e_fwd_d = '0;
  string e_tag = "R1";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] pack_iss(input logic [2:0] k, input logic [AW-1:0] a,
                                           input logic [DW-1:0] d, input logic dr);
    return {12'd0, k, a, d, dr};
  endfunction

  function automatic bit model_hit(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bit h = 0;
    d = '0;
    for (int k = 0; k < ma.size(); k++) if (ma[k] == a) begin h = 1; d = md[k]; end
    return h;
  endfunction

  task automatic step(input int p_store, input int lat_max);
    logic [DW-1:0] hd;
    bit hit, exp_rdy, acc, drain, ld_wait;
    string rtag;
    // outputs produced by the last edge
    chk(iss_valid == e_iss_v && (!e_iss_v ||
        pack_iss(iss_kind, iss_addr, iss_data, iss_drain) == e_iss), e_tag,
        iss_valid ? pack_iss(iss_kind, iss_addr, iss_data, iss_drain) : 64'd0,
        e_iss_v ? e_iss : 64'd0);
    chk(fwd_valid == e_fwd_v && (!e_fwd_v || fwd_data == e_fwd_d), "R8 forward",
        {31'd0, fwd_valid, fwd_data}, {31'd0, e_fwd_v, e_fwd_d});
    chk(sq_deq == e_deq, "R11 dequeue", 64'(sq_deq), 64'(e_deq));
    // new inputs
    req_valid = ($urandom % 100) < 85;
    begin
      int r = $urandom % 100;
      if (r < p_store) req_kind = 3'd1;
      else if (r < p_store + (100 - p_store) * 3 / 4) req_kind = 3'd0;
      else req_kind = 3'(2 + $urandom % 3);
    end
    req_addr   = AW'(16'h0100 + ($urandom % 4) * 4);
    req_wdata  = $urandom;
    cache_done = busy && lat == 0;
    #1;
    hit = model_hit(req_addr, hd);
    unique case (req_kind)
      3'd0: begin exp_rdy = hit || !busy; rtag = hit ? "R8 ready" : (busy ? "R10 ready" : "R3 ready"); end
      3'd1: begin exp_rdy = ma.size() < DEPTH; rtag = exp_rdy ? "R2 ready" : "R9 ready"; end
      3'd4: begin exp_rdy = ma.size() == 0 && !busy; rtag = "R5 ready"; end
      default: begin exp_rdy = ma.size() == 0 && !busy; rtag = "R4 ready"; end
    endcase
    if (req_valid) chk(req_ready == exp_rdy, rtag, 64'(req_ready), 64'(exp_rdy));
    // expectations for the next edge
    acc     = req_valid && exp_rdy;
    ld_wait = req_valid && req_kind == 3'd0;
    drain   = ma.size() > 0 && !busy && !ld_wait;
    e_iss_v = 0; e_fwd_v = 0;
    e_tag   = busy ? "R10 issue" : (req_kind == 3'd1 && acc ? "R2 issue" : "R6 issue");
    if (acc && req_kind == 3'd0 && !hit) begin
      e_iss_v = 1; e_iss = pack_iss(3'd0, req_addr, req_wdata, 1'b0); e_tag = "R3 issue";
    end else if (acc && (req_kind == 3'd2 || req_kind == 3'd3)) begin
      e_iss_v = 1; e_iss = pack_iss(req_kind, req_addr, req_wdata, 1'b0); e_tag = "R4 issue";
    end else if (drain) begin
      e_iss_v = 1; e_iss = pack_iss(3'd1, ma[0], md[0], 1'b1); e_tag = "R6 issue";
    end else if (acc && req_kind == 3'd4) begin
      e_tag = "R5 issue";
    end else if (ld_wait && ma.size() > 0 && !busy) begin
      e_tag = "R7 issue";
    end
    if (acc && req_kind == 3'd0 && hit) begin e_fwd_v = 1; e_fwd_d = hd; end
    e_deq = cache_done && busy_drain;
    if (e_deq) begin void'(ma.pop_front()); void'(md.pop_front()); end
    if (acc && req_kind == 3'd1) begin ma.push_back(req_addr); md.push_back(req_wdata); end
    if (cache_done) busy = 0;
    else if (busy) lat--;
    if (e_iss_v) begin busy = 1; busy_drain = drain && !(acc && req_kind != 3'd1 && req_kind != 3'd4); lat = $urandom % (lat_max + 1); end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!iss_valid && !fwd_valid && !sq_deq, "R1 in reset",
        {61'd0, iss_valid, fwd_valid, sq_deq}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!iss_valid && !fwd_valid && !sq_deq, "R1 after reset",
        {61'd0, iss_valid, fwd_valid, sq_deq}, 64'd0);
    req_valid = 1'b1; req_kind = 3'd4;
    #1;
    chk(req_ready == 1'b1, "R1 fence accepted on empty queue", 64'(req_ready), 64'd1);
    e_tag = "R1 no issue";
    @(negedge clk);
    req_valid = 1'b0;
    // directed: fill the queue behind a slow cache
    for (int k = 0; k < 40; k++) step(90, 12);
    for (int k = 0; k < 1200; k++) step(65, 10);
    for (int k = 0; k < 1500; k++) step(30, 3);
    for (int k = 0; k < 600; k++) step(10, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule